// File: doc/BRIEF.md
# DMA Page Register and Address Composer

This block sits beside a pair of PC-style DMA controllers. One controller moves bytes and serves channels 0 to 3. The other moves 16-bit words and serves channels 5 to 7. Channel 4 links the two controllers and has no page of its own. The block holds one 8-bit page value for each of the seven data channels and one for the memory-refresh cycle. Software loads and reads these values through byte-wide I/O ports at fixed addresses.

While a transfer runs, the block takes the 16-bit offset from the active controller and joins it with the page of the winning channel to form a 24-bit system memory address.

- **Byte channels:** the whole page sits above the 16-bit offset, so one transfer stays inside a 64 KB page.
- **Word channels:** the offset moves up one bit and bit 0 is held at zero. The lowest page bit is then dropped, so one transfer covers up to 64 K words (128 KB) on even addresses.
- **Refresh:** refresh cycles use the byte layout with the refresh page. For correct operation software must leave that page at 00h.

The address path is purely combinational from the channel-active inputs to the address outputs. Register writes take effect on the clock edge.

Top module: `dma_page_addr`

## Requirements
- R1: After reset, every one of the eight page registers reads back as 00h.
- R2: The decoded I/O ports are 0087h (ch0), 0083h (ch1), 0081h (ch2), 0082h (ch3), 008Bh (ch5), 0089h (ch6), 008Ah (ch7) and 008Fh (refresh). All 16 address bits are compared. A write with `io_wr` high to one of these ports stores `io_wdata` at that clock edge. While `io_rd` is high with a decoded port, `io_rdata` shows the stored value and `io_rvalid` is 1 in the same cycle.
- R3: A read of any other port gives `io_rdata` = 00h with `io_rvalid` = 0. A write to any other port, including 0080h where channel 4 would sit, changes no page register.
- R4: When a byte channel c (0..3) wins, `mem_addr` = {page_c[7:0], `ctl_addr`[15:0]} and `mem_addr_valid` = 1.
- R5: When a word channel c (5..7) wins, `mem_addr` = {page_c[7:1], `ctl_addr`[15:0], 1'b0}. Page bit 0 has no effect and bit 0 of the address is always 0.
- R6: When `refresh_act` is high and no data channel is active, `mem_addr` = {refresh page, `ctl_addr`} and `mem_addr_valid` = 1.
- R7: Among the set bits of `chan_act` (bit c = channel c), the lowest-numbered channel wins. Bit 4 is ignored. Any data channel beats refresh.
- R8: With no data channel (bits 0..3, 5..7) active and `refresh_act` low, `mem_addr` = 0 and `mem_addr_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, 0 unless a decoded port is read |
| io_rvalid | output | 1 | High when a decoded port is read |
| chan_act | input | 8 | One bit per channel active (bit 4 ignored) |
| refresh_act | input | 1 | Refresh cycle in progress |
| ctl_addr | input | 16 | Offset from the active controller |
| mem_addr | output | 24 | Composed system memory address |
| mem_addr_valid | output | 1 | High when a channel or refresh is selected |

## Verification
The port map is checked with a sweep over all 256 low I/O addresses, plus a set of addresses with upper bits set:
- reads separate the eight decoded ports from all the rest;
- writes to every undecoded address show that none of them aliases onto a register.

Address assembly is then checked over all 256 `chan_act` patterns, each with and without refresh and with a changing offset. This separates the priority order, the ignored bit 4, refresh losing to any channel, and the idle case.

Two further sweeps write all 256 page values:
- one into a byte channel, to confirm the whole byte reaches the top of the address;
- one into a word channel, where odd and even pages must give the same address with bit 0 clear.

// File: rtl/dma_page_pkg.sv
// Package: dma_page_pkg
// Shared constants, the port map and the selection record for the DMA page
// register block. Slots 0..3 are channels 0..3, slots 4..6 are channels 5..7,
// slot 7 is refresh. Assumes exactly eight channels, as the controller pair has.
package dma_page_pkg;

    localparam int NUM_CHAN     = 8;
    localparam int NUM_SLOTS    = 8;
    localparam int SLOT_W       = $clog2(NUM_SLOTS);
    localparam int REFRESH_SLOT = NUM_SLOTS - 1;
    localparam int CASCADE_CHAN = 4;

    typedef struct packed {
        logic              valid;
        logic              word;
        logic [SLOT_W-1:0] slot;
    } dma_sel_t;

    // Returns the 8-bit I/O port of a storage slot.
    function automatic logic [7:0] slot_port(input int unsigned s);
        logic [7:0] p;
        case (s)
            0:       p = 8'h87;
            1:       p = 8'h83;
            2:       p = 8'h81;
            3:       p = 8'h82;
            4:       p = 8'h8B;
            5:       p = 8'h89;
            6:       p = 8'h8A;
            default: p = 8'h8F;
        endcase
        return p;
    endfunction

    // Maps a data channel number to its storage slot (channel 4 excluded).
    function automatic logic [SLOT_W-1:0] chan_slot(input int unsigned c);
        return (c < CASCADE_CHAN) ? SLOT_W'(c) : SLOT_W'(c - 1);
    endfunction

endpackage

// File: rtl/dma_page_decode.sv
// Module: dma_page_decode
// Compares the full I/O address against each slot's port. It gives a one-hot
// match vector, a hit flag and the encoded slot number.
// Assumes the upper I/O address bits must be zero for a match.
module dma_page_decode
    import dma_page_pkg::*;
#(
    parameter int IO_AW = 16
) (
    input  logic [IO_AW-1:0]     io_addr,
    output logic [NUM_SLOTS-1:0] match,
    output logic                 hit,
    output logic [SLOT_W-1:0]    slot
);

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_cmp
            // Per-slot full-width address comparator.
            assign match[g] = (io_addr == IO_AW'(slot_port(g)));
        end
    endgenerate

    // Any-slot hit flag.
    assign hit = |match;

    // Encode the one-hot match into a slot number.
    always_comb begin
        slot = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (match[i]) begin
                slot = SLOT_W'(i);
            end
        end
    end

endmodule

// File: rtl/dma_page_regfile.sv
// Module: dma_page_regfile
// Holds one page register per slot. A slot loads when write and match are
// both high at the clock edge. Synchronous active-low reset clears every slot.
// Assumes at most one match bit is set.
module dma_page_regfile
    import dma_page_pkg::*;
#(
    parameter int PG_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [NUM_SLOTS-1:0]            match,
    input  logic [PG_W-1:0]                 wdata,
    output logic [NUM_SLOTS-1:0][PG_W-1:0]  pages
);

    genvar g;
    generate
        for (g = 0; g < NUM_SLOTS; g++) begin : g_reg
            logic [PG_W-1:0] q;

            // Page register storage for one slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q <= '0;
                end else if (wr && match[g]) begin
                    q <= wdata;
                end
            end

            assign pages[g] = q;
        end
    endgenerate

endmodule

// File: rtl/dma_page_select.sv
// Module: dma_page_select
// Chooses the source of the memory address. The lowest active data channel
// wins, the cascade channel 4 is ignored, and refresh is the last choice.
// Also reports whether the winner is a word channel.
module dma_page_select
    import dma_page_pkg::*;
(
    input  logic [NUM_CHAN-1:0] chan_act,
    input  logic                refresh_act,
    output dma_sel_t            sel
);

    // Priority pick: scanning from high to low lets the lowest channel win.
    always_comb begin
        sel = '0;
        if (refresh_act) begin
            sel.valid = 1'b1;
            sel.word  = 1'b0;
            sel.slot  = SLOT_W'(REFRESH_SLOT);
        end
        for (int c = NUM_CHAN - 1; c >= 0; c--) begin
            if (c != CASCADE_CHAN && chan_act[c]) begin
                sel.valid = 1'b1;
                sel.word  = (c > CASCADE_CHAN);
                sel.slot  = chan_slot(c);
            end
        end
    end

endmodule

// File: rtl/dma_page_compose.sv
// Module: dma_page_compose
// Joins the selected page with the controller offset. The byte layout places
// the page above the offset. The word layout drops page bit 0, shifts the
// offset up one bit and forces bit 0 to zero. With no selection the output is 0.
module dma_page_compose
    import dma_page_pkg::*;
#(
    parameter int PG_W = 8,
    parameter int CA_W = 16,
    localparam int SA_W = PG_W + CA_W
) (
    input  dma_sel_t                        sel,
    input  logic [NUM_SLOTS-1:0][PG_W-1:0]  pages,
    input  logic [CA_W-1:0]                 ctl_addr,
    output logic [SA_W-1:0]                 mem_addr,
    output logic                            mem_addr_valid
);

    logic [PG_W-1:0] page;

    // Page of the selected slot.
    assign page = pages[sel.slot];

    // Address assembly in byte or word layout.
    always_comb begin
        if (!sel.valid) begin
            mem_addr = '0;
        end else if (sel.word) begin
            mem_addr = {page[PG_W-1:1], ctl_addr, 1'b0};
        end else begin
            mem_addr = {page, ctl_addr};
        end
    end

    // The address is valid whenever a source is selected.
    assign mem_addr_valid = sel.valid;

endmodule

// File: rtl/dma_page_addr.sv
// Module: dma_page_addr (top)
// Page registers with I/O decode and readback, and the 24-bit DMA memory
// address composer. Readback and address paths are combinational.
// Register writes are synchronous. Assumes a single clock domain.
module dma_page_addr
    import dma_page_pkg::*;
#(
    parameter int IO_AW = 16,
    parameter int PG_W  = 8,
    parameter int CA_W  = 16,
    localparam int SA_W = PG_W + CA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IO_AW-1:0]    io_addr,
    input  logic                io_wr,
    input  logic                io_rd,
    input  logic [PG_W-1:0]     io_wdata,
    output logic [PG_W-1:0]     io_rdata,
    output logic                io_rvalid,
    input  logic [NUM_CHAN-1:0] chan_act,
    input  logic                refresh_act,
    input  logic [CA_W-1:0]     ctl_addr,
    output logic [SA_W-1:0]     mem_addr,
    output logic                mem_addr_valid
);

    logic [NUM_SLOTS-1:0]           match;
    logic                           hit;
    logic [SLOT_W-1:0]              rd_slot;
    logic [NUM_SLOTS-1:0][PG_W-1:0] pages;
    dma_sel_t                       sel;

    dma_page_decode #(.IO_AW(IO_AW)) u_dec (
        .io_addr (io_addr),
        .match   (match),
        .hit     (hit),
        .slot    (rd_slot)
    );

    dma_page_regfile #(.PG_W(PG_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (io_wr),
        .match (match),
        .wdata (io_wdata),
        .pages (pages)
    );

    dma_page_select u_sel (
        .chan_act    (chan_act),
        .refresh_act (refresh_act),
        .sel         (sel)
    );

    dma_page_compose #(.PG_W(PG_W), .CA_W(CA_W)) u_cmp (
        .sel            (sel),
        .pages          (pages),
        .ctl_addr       (ctl_addr),
        .mem_addr       (mem_addr),
        .mem_addr_valid (mem_addr_valid)
    );

    // Readback: the stored value on a decoded read, zero otherwise.
    assign io_rvalid = io_rd && hit;
    assign io_rdata  = io_rvalid ? pages[rd_slot] : '0;

endmodule

// File: rtl/dma_page_addr_chk.sv
// Module: dma_page_addr_chk
// Assertion checker bound to dma_page_addr. It watches only the top-level ports.
module dma_page_addr_chk #(
    parameter int IO_AW = 16,
    parameter int PG_W  = 8,
    parameter int CA_W  = 16,
    localparam int SA_W = PG_W + CA_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IO_AW-1:0] io_addr,
    input logic             io_wr,
    input logic             io_rd,
    input logic [PG_W-1:0]  io_wdata,
    input logic [PG_W-1:0]  io_rdata,
    input logic             io_rvalid,
    input logic [7:0]       chan_act,
    input logic             refresh_act,
    input logic [CA_W-1:0]  ctl_addr,
    input logic [SA_W-1:0]  mem_addr,
    input logic             mem_addr_valid
);

    logic any_data;
    assign any_data = |{chan_act[7:5], chan_act[3:0]};

    AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(io_wr) && io_rd && io_rvalid && (io_addr == $past(io_addr)))
        |-> (io_rdata == $past(io_wdata))); // R2

    AST_UNDECODED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rvalid |-> (io_rdata == '0)); // R3

    AST_BYTE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_act[3:0] != 4'b0) |-> (mem_addr_valid && mem_addr[CA_W-1:0] == ctl_addr)); // R4

    AST_WORD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_act[3:0] == 4'b0 && chan_act[7:5] != 3'b0)
        |-> (mem_addr_valid && !mem_addr[0] && mem_addr[CA_W:1] == ctl_addr)); // R5

    AST_REFRESH_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_act && !any_data) |-> (mem_addr_valid && mem_addr[CA_W-1:0] == ctl_addr)); // R6

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!refresh_act && !any_data) |-> (!mem_addr_valid && mem_addr == '0)); // R8

endmodule

bind dma_page_addr dma_page_addr_chk #(.IO_AW(IO_AW), .PG_W(PG_W), .CA_W(CA_W)) u_chk (.*);

// File: tb/sim_dma_page_addr.sv
module sim_dma_page_addr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic [7:0]  chan_act = '0;
    logic        refresh_act = 1'b0;
    logic [15:0] ctl_addr = '0;
    logic [23:0] mem_addr;
    logic        mem_addr_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model: page per channel 0..7, index 8 = refresh (index 4 unused).
    logic [7:0] model [0:8];

    always #4 clk = ~clk;

    dma_page_addr u0 (.*);

    // Port of a channel index (8 = refresh), or 0 for none.
    function automatic logic [15:0] port_of(input int k);
        case (k)
            0: return 16'h0087;
            1: return 16'h0083;
            2: return 16'h0081;
            3: return 16'h0082;
            5: return 16'h008B;
            6: return 16'h0089;
            7: return 16'h008A;
            8: return 16'h008F;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic int chan_of_port(input logic [15:0] a);
        for (int k = 0; k <= 8; k++) begin
            if (k != 4 && port_of(k) == a) return k;
        end
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [15:0] a);
        int k;
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2;
        k = chan_of_port(a);
        if (k >= 0) check(req, {23'b0, io_rvalid, io_rdata}, {23'b0, 1'b1, model[k]});
        else        check(req, {23'b0, io_rvalid, io_rdata}, 32'h0);
        io_rd = 1'b0;
    endtask

    function automatic logic [24:0] exp_addr(input logic [7:0] act, input logic rf,
                                             input logic [15:0] off);
        for (int c = 0; c < 8; c++) begin
            if (c != 4 && act[c]) begin
                if (c < 4) return {1'b1, model[c], off};
                return {1'b1, model[c][7:1], off, 1'b0};
            end
        end
        if (rf) return {1'b1, model[8], off};
        return 25'h0;
    endfunction

    task automatic addr_check(input string req, input logic [7:0] act, input logic rf,
                              input logic [15:0] off);
        @(negedge clk);
        chan_act = act; refresh_act = rf; ctl_addr = off;
        #2;
        check(req, {7'b0, mem_addr_valid, mem_addr}, {7'b0, exp_addr(act, rf, off)});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k <= 8; k++) model[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values on every decoded port.
        for (int k = 0; k <= 8; k++) if (k != 4) read_check("R1", port_of(k));
        // R8: idle output after reset.
        addr_check("R8", 8'h00, 1'b0, 16'hBEEF);

        // R2: load distinct values (odd and even) and read all 256 low ports.
        for (int k = 0; k <= 8; k++) begin
            if (k != 4) begin
                model[k] = 8'(8'h5B + k * 8'd37);
                io_write(port_of(k), model[k]);
            end
        end
        for (int a = 0; a < 256; a++) read_check("R2", 16'(a));

        // R3: upper address bits set are not decoded.
        for (int k = 1; k < 16; k++) read_check("R3", 16'(k << 8) | 16'h0087);
        // R3: writes to every undecoded port (incl. 0080h) change nothing.
        for (int a = 0; a < 256; a++) begin
            if (chan_of_port(16'(a)) < 0) io_write(16'(a), 8'hFF);
        end
        io_write(16'h0187, 8'hFF);
        for (int k = 0; k <= 8; k++) if (k != 4) read_check("R3", port_of(k));

        // R7 (with R4, R5, R6, R8): every channel pattern, with and without refresh.
        for (int p = 0; p < 256; p++) begin
            addr_check("R7", 8'(p), 1'b0, 16'(p * 16'd257 + 16'd3));
            addr_check("R7", 8'(p), 1'b1, 16'(16'hFFFF - p * 16'd129));
        end

        // R4: all page values on byte channel 0 reach A23..A16.
        for (int v = 0; v < 256; v++) begin
            model[0] = 8'(v);
            io_write(port_of(0), 8'(v));
            addr_check("R4", 8'h01, 1'b0, 16'(v * 16'd251));
        end
        // R5: all page values on word channel 5; bit 0 ignored, A0 = 0.
        for (int v = 0; v < 256; v++) begin
            model[5] = 8'(v);
            io_write(port_of(5), 8'(v));
            addr_check("R5", 8'h20, 1'b0, 16'(v * 16'd509 + 16'd1));
        end
        // R6: refresh page 00h and a nonzero refresh page.
        model[8] = 8'h00; io_write(port_of(8), 8'h00);
        addr_check("R6", 8'h10, 1'b1, 16'h1234);
        model[8] = 8'hC3; io_write(port_of(8), 8'hC3);
        addr_check("R6", 8'h00, 1'b1, 16'hFFFF);
        // R8: only the cascade bit set, no refresh.
        addr_check("R8", 8'h10, 1'b0, 16'hAAAA);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule